// File: doc/BRIEF.md
# Three-Instruction Control Decoder

This block is the control decoder of a small 4-bit processor. It looks at the 8-bit instruction register and the four machine phases. From them it produces every bus-drive enable and register write strobe the datapath needs. There are three instruction classes:

- **Load-immediate:** a 7-bit constant taken from the instruction goes into A.
- **Move:** copies one of several sources to one of several destinations.
- **ALU operation:** writes the ALU result into A.

Every instruction passes through a temporary register T. The source drives the bus in phase M1, T captures the bus in M2 and drives it in M3, and the destination captures it in M4.

A move into the program counter is a jump. The jump is cancelled when the datapath reports that B holds all ones. In that case no write strobe is issued and the program counter simply steps forward. The decoder is purely combinational, so the phase generator sets every strobe's timing, including the overlap between adjacent phases.

Top module: `fbd_ctrl_decoder`

## Requirements
- R1: When ir_i[7]=1 (load-immediate), src_oe_o drives only bit 5 (immediate) in M1 and dst_we_o drives only bit 0 (A) in M4. imm_o always equals ir_i[6:0], whatever b_full_i is.
- R2: When ir_i[7:6]=01 (ALU), src_oe_o drives only bit 6 (ALU driver) in M1 and dst_we_o drives only bit 0 (A) in M4. alu_mode_o equals ir_i[4] and alu_sel_o equals ir_i[3:0]. For any other class both of these outputs are zero.
- R3: When ir_i[7:6]=00 (move), the source code ir_i[5:3] decodes in M1 as follows: 0 gives src_oe_o bit 0 (A), 1 gives bit 1 (B), 2 gives bit 2 (RAM), 3 gives bit 3 (input port 0) and 4 gives bit 4 (input port 1). Codes 5 to 7 enable nothing. A move from A to A therefore drives A and writes A, with no other effect.
- R4: For a move, the destination code ir_i[2:0] decodes in M4 as follows: 0 gives dst_we_o bit 0 (A), 1 gives bit 1 (B), 2 gives bit 2 (PC), 3 gives bit 3 (RAM), 4 gives bit 4 (output port 0) and 5 gives bit 5 (output port 1). Codes 6 and 7 write nothing.
- R5: phase_i bit 0 is M1 and bit 3 is M4. Source enables are active only while M1 is high, and destination writes only while M4 is high. Each of the two output vectors has at most one bit set.
- R6: t_we_o follows M2 (phase_i[1]) and t_oe_o follows M3 (phase_i[2]) for every instruction.
- R7: A move into PC while b_full_i=1 leaves dst_we_o all zero in M4. The flag has no effect on any other destination.
- R8: pc_inc_o is high in M4 exactly when PC is not being written, and is never high together with dst_we_o[2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ir_i | input | 8 | Instruction register contents |
| phase_i | input | 4 | Machine phases M1..M4 in bits 0..3 |
| b_full_i | input | 1 | B register holds all ones |
| src_oe_o | output | 7 | One-hot bus drive enables: A, B, RAM, IN0, IN1, IMM, ALU |
| dst_we_o | output | 6 | One-hot write strobes: A, B, PC, RAM, OUT0, OUT1 |
| t_we_o | output | 1 | Temporary register write |
| t_oe_o | output | 1 | Temporary register bus drive |
| pc_inc_o | output | 1 | Program counter step |
| imm_o | output | 7 | Immediate field |
| alu_mode_o | output | 1 | ALU mode select |
| alu_sel_o | output | 4 | ALU function select |

## Verification
The bench targets the following corner cases:

- **Unused source and destination codes.** A decoder that aliased them onto a real register would corrupt A or an output port during what should be a harmless move.
- **Jump cancellation.** It is exercised with the flag both clear and set. The bench confirms that the flag leaves load-immediate and moves to other destinations alone. A design that cancelled too broadly would drop writes to A or B. One that forgot the program counter step would stall the program on a skipped jump.
- **Overlapping phases.** A design that shared logic between phases would either miss the T capture or drive two sources at once.
- **ALU control fields.** These are checked for zero outside ALU instructions, so a decoder that leaked them would disturb the ALU selection.

// File: rtl/fbd_pkg.sv
`timescale 1ns/1ps
package fbd_pkg;
  typedef enum logic [1:0] {
    OP_LDI = 2'd0,
    OP_MOV = 2'd1,
    OP_ALU = 2'd2
  } op_e;

  // one-hot positions; codes equal positions for move fields
  localparam int SRC_A    = 0;
  localparam int SRC_B    = 1;
  localparam int SRC_RAM  = 2;
  localparam int SRC_IN0  = 3;
  localparam int DST_A    = 0;
  localparam int DST_B    = 1;
  localparam int DST_PC   = 2;
  localparam int DST_RAM  = 3;
  localparam int DST_OUT0 = 4;
endpackage

// File: rtl/fbd_opclass.sv
`timescale 1ns/1ps
module fbd_opclass
  import fbd_pkg::*;
(
  input  logic [1:0] ir_hi_i,
  output op_e        op_o
);
  always_comb begin
    if (ir_hi_i[1])      op_o = OP_LDI;
    else if (ir_hi_i[0]) op_o = OP_ALU;
    else                 op_o = OP_MOV;
  end
endmodule

// File: rtl/fbd_src_dec.sv
`timescale 1ns/1ps
module fbd_src_dec
  import fbd_pkg::*;
#(
  parameter int FIELD_W = 3,
  parameter int N_IN    = 2,
  localparam int SRC_N  = SRC_IN0 + N_IN + 2
) (
  input  op_e                op_i,
  input  logic [FIELD_W-1:0] code_i,
  input  logic               en_i,
  output logic [SRC_N-1:0]   oe_o
);
  localparam int IMM_IDX = SRC_IN0 + N_IN;
  localparam int ALU_IDX = IMM_IDX + 1;

  logic [SRC_N-1:0] mov_sel;

  assign mov_sel[SRC_A]   = (code_i == FIELD_W'(SRC_A));
  assign mov_sel[SRC_B]   = (code_i == FIELD_W'(SRC_B));
  assign mov_sel[SRC_RAM] = (code_i == FIELD_W'(SRC_RAM));
  for (genvar k = 0; k < N_IN; k++) begin : g_in
    assign mov_sel[SRC_IN0+k] = (code_i == FIELD_W'(SRC_IN0 + k));
  end
  assign mov_sel[IMM_IDX] = 1'b0;
  assign mov_sel[ALU_IDX] = 1'b0;

  always_comb begin
    oe_o = '0;
    if (en_i) begin
      unique case (op_i)
        OP_LDI:  oe_o[IMM_IDX] = 1'b1;
        OP_ALU:  oe_o[ALU_IDX] = 1'b1;
        OP_MOV:  oe_o = mov_sel;
        default: oe_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/fbd_dst_dec.sv
`timescale 1ns/1ps
module fbd_dst_dec
  import fbd_pkg::*;
#(
  parameter int FIELD_W = 3,
  parameter int N_OUT   = 2,
  localparam int DST_N  = DST_OUT0 + N_OUT
) (
  input  op_e                op_i,
  input  logic [FIELD_W-1:0] code_i,
  input  logic               en_i,
  input  logic               b_full_i,
  output logic [DST_N-1:0]   we_o
);
  logic [DST_N-1:0] mov_sel;

  assign mov_sel[DST_A]   = (code_i == FIELD_W'(DST_A));
  assign mov_sel[DST_B]   = (code_i == FIELD_W'(DST_B));
  // conditional jump: skipped when B is all ones
  assign mov_sel[DST_PC]  = (code_i == FIELD_W'(DST_PC)) && !b_full_i;
  assign mov_sel[DST_RAM] = (code_i == FIELD_W'(DST_RAM));
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assign mov_sel[DST_OUT0+k] = (code_i == FIELD_W'(DST_OUT0 + k));
  end

  always_comb begin
    we_o = '0;
    if (en_i) begin
      unique case (op_i)
        OP_LDI, OP_ALU: we_o[DST_A] = 1'b1;
        OP_MOV:         we_o = mov_sel;
        default:        we_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/fbd_ctrl_decoder.sv
`timescale 1ns/1ps
module fbd_ctrl_decoder
  import fbd_pkg::*;
#(
  parameter int IR_W    = 8,
  parameter int FIELD_W = 3,
  parameter int N_IN    = 2,
  parameter int N_OUT   = 2,
  parameter int ALU_S_W = 4,
  localparam int IMM_W  = IR_W - 1,
  localparam int SRC_N  = SRC_IN0 + N_IN + 2,
  localparam int DST_N  = DST_OUT0 + N_OUT
) (
  input  logic [IR_W-1:0]    ir_i,
  input  logic [3:0]         phase_i,
  input  logic               b_full_i,
  output logic [SRC_N-1:0]   src_oe_o,
  output logic [DST_N-1:0]   dst_we_o,
  output logic               t_we_o,
  output logic               t_oe_o,
  output logic               pc_inc_o,
  output logic [IMM_W-1:0]   imm_o,
  output logic               alu_mode_o,
  output logic [ALU_S_W-1:0] alu_sel_o
);
  op_e op;

  fbd_opclass u_opclass (
    .ir_hi_i (ir_i[IR_W-1:IR_W-2]),
    .op_o    (op)
  );

  fbd_src_dec #(.FIELD_W(FIELD_W), .N_IN(N_IN)) u_src (
    .op_i   (op),
    .code_i (ir_i[2*FIELD_W-1:FIELD_W]),
    .en_i   (phase_i[0]),
    .oe_o   (src_oe_o)
  );

  fbd_dst_dec #(.FIELD_W(FIELD_W), .N_OUT(N_OUT)) u_dst (
    .op_i     (op),
    .code_i   (ir_i[FIELD_W-1:0]),
    .en_i     (phase_i[3]),
    .b_full_i (b_full_i),
    .we_o     (dst_we_o)
  );

  assign t_we_o   = phase_i[1];
  assign t_oe_o   = phase_i[2];
  assign pc_inc_o = phase_i[3] && !dst_we_o[DST_PC];
  assign imm_o    = ir_i[IMM_W-1:0];

  always_comb begin
    alu_mode_o = 1'b0;
    alu_sel_o  = '0;
    if (op == OP_ALU) begin
      alu_mode_o = ir_i[ALU_S_W];
      alu_sel_o  = ir_i[ALU_S_W-1:0];
    end
  end
endmodule

// File: rtl/fbd_ctrl_decoder_chk.sv
`timescale 1ns/1ps
module fbd_ctrl_decoder_chk #(
  parameter int SRC_N = 7,
  parameter int DST_N = 6
) (
  input logic [7:0]       ir_i,
  input logic [3:0]       phase_i,
  input logic             b_full_i,
  input logic [SRC_N-1:0] src_oe_o,
  input logic [DST_N-1:0] dst_we_o,
  input logic             pc_inc_o
);
  always_comb begin
    if (!$isunknown({ir_i, phase_i, b_full_i, src_oe_o, dst_we_o, pc_inc_o})) begin
      AST_SRC_ONEHOT: assert ($onehot0(src_oe_o));                       // R5
      AST_DST_ONEHOT: assert ($onehot0(dst_we_o));                       // R5
      AST_SRC_IN_M1:  assert (src_oe_o == '0 || phase_i[0]);             // R5
      AST_DST_IN_M4:  assert (dst_we_o == '0 || phase_i[3]);             // R5
      AST_PC_EXCL:    assert (!(pc_inc_o && dst_we_o[2]));               // R8
      AST_JUMP_SKIP:  assert (!(b_full_i && dst_we_o[2]));               // R7
      AST_LDI_DST:    assert (!(ir_i[7] && phase_i[3]) || dst_we_o == DST_N'(1)); // R1
      AST_ALU_SRC:    assert (!(ir_i[7:6] == 2'b01 && phase_i[0])
                              || src_oe_o == SRC_N'(1) << (SRC_N - 1));  // R2
    end
  end
endmodule

bind fbd_ctrl_decoder fbd_ctrl_decoder_chk #(.SRC_N(SRC_N), .DST_N(DST_N)) u_chk (
  .ir_i     (ir_i),
  .phase_i  (phase_i),
  .b_full_i (b_full_i),
  .src_oe_o (src_oe_o),
  .dst_we_o (dst_we_o),
  .pc_inc_o (pc_inc_o)
);

// File: tb/sim_fbd_ctrl_decoder.sv
`timescale 1ns/1ps
module sim_fbd_ctrl_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ir = '0;
  logic [3:0] phase = '0;
  logic       b_full = 1'b0;
  logic [6:0] src_oe;
  logic [5:0] dst_we;
  logic       t_we, t_oe, pc_inc, alu_mode;
  logic [6:0] imm;
  logic [3:0] alu_sel;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fbd_ctrl_decoder u0 (
    .ir_i(ir), .phase_i(phase), .b_full_i(b_full),
    .src_oe_o(src_oe), .dst_we_o(dst_we), .t_we_o(t_we), .t_oe_o(t_oe),
    .pc_inc_o(pc_inc), .imm_o(imm), .alu_mode_o(alu_mode), .alu_sel_o(alu_sel)
  );

  // {ir, b_full, expected source one-hot, expected destination one-hot}
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {8'h85, 1'b0, 7'b0100000, 6'b000001},  // R1 load-immediate
    {8'hFF, 1'b1, 7'b0100000, 6'b000001},  // R1 flag ignored
    {8'h4B, 1'b0, 7'b1000000, 6'b000001},  // R2 ALU
    {8'h5F, 1'b1, 7'b1000000, 6'b000001},  // R2 flag ignored
    {8'h00, 1'b0, 7'b0000001, 6'b000001},  // R3 A to A
    {8'h0A, 1'b0, 7'b0000010, 6'b000100},  // R4 B to PC, jump taken
    {8'h0A, 1'b1, 7'b0000010, 6'b000000},  // R7 jump skipped
    {8'h13, 1'b0, 7'b0000100, 6'b001000},  // RAM to RAM
    {8'h1C, 1'b0, 7'b0001000, 6'b010000},  // IN0 to OUT0
    {8'h25, 1'b1, 7'b0010000, 6'b100000},  // IN1 to OUT1, flag ignored
    {8'h2E, 1'b0, 7'b0000000, 6'b000000},  // unused codes 5 / 6
    {8'h3F, 1'b0, 7'b0000000, 6'b000000},  // unused codes 7 / 7
    {8'h01, 1'b1, 7'b0000001, 6'b000010},  // A to B, flag ignored
    {8'h30, 1'b0, 7'b0000000, 6'b000001}   // unused src 6 to A
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] i, input logic bf, input logic [3:0] ph);
    @(posedge clk);
    ir = i; b_full = bf; phase = ph;
    @(negedge clk);
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R5 reset state: no phase active, nothing driven
    chk("R5 reset src", 32'(src_oe), 0);
    chk("R5 reset dst", 32'(dst_we), 0);
    chk("R8 reset pc_inc", 32'(pc_inc), 0);
    chk("R6 reset t", 32'({t_we, t_oe}), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] vi;
        logic [6:0] es;
        logic [5:0] ed;
        string      st, dt;
        vi = VEC[v][21:14];
        es = VEC[v][12:6];
        ed = VEC[v][5:0];
        st = vi[7] ? "R1 src" : (vi[6] ? "R2 src" : "R3 src");
        dt = vi[7] ? "R1 dst" : (vi[6] ? "R2 dst" :
             (vi[2:0] == 3'd2 ? "R7 dst" : "R4 dst"));
        apply(vi, VEC[v][13], 4'(1 << p));
        chk(st, 32'(src_oe), 32'(p == 0 ? es : 7'd0));
        chk(dt, 32'(dst_we), 32'(p == 3 ? ed : 6'd0));
        chk("R6 t strobes", 32'({t_we, t_oe}), 32'({p == 1, p == 2}));
        chk("R8 pc_inc", 32'(pc_inc), 32'(p == 3 && !ed[2]));
      end
    end

    // R1 immediate field
    apply(8'hD5, 1'b1, 4'b0001);
    chk("R1 imm", 32'(imm), 32'h55);
    // R2 ALU control fields
    apply(8'h5A, 1'b0, 4'b0000);
    chk("R2 alu_mode", 32'(alu_mode), 1);
    chk("R2 alu_sel", 32'(alu_sel), 32'hA);
    apply(8'h1A, 1'b0, 4'b0000);
    chk("R2 fields zero on move", 32'({alu_mode, alu_sel}), 0);
    apply(8'hDA, 1'b0, 4'b0000);
    chk("R2 fields zero on ldi", 32'({alu_mode, alu_sel}), 0);
    // R5 / R6 overlapping M1 and M2
    apply(8'h0A, 1'b0, 4'b0011);
    chk("R5 overlap src", 32'(src_oe), 32'b0000010);
    chk("R5 overlap dst", 32'(dst_we), 0);
    chk("R6 overlap t_we", 32'(t_we), 1);
    // R7 / R8 overlapping M3 and M4 on skipped jump
    apply(8'h22, 1'b1, 4'b1100);
    chk("R7 overlap dst", 32'(dst_we), 0);
    chk("R8 overlap pc_inc", 32'(pc_inc), 1);
    chk("R6 overlap t_oe", 32'(t_oe), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule